// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

The bridge is a target on a simple host register bus. It holds a command word, an upper-offset word and a data word. Software stages an upper offset and, for writes, a payload. It then writes the command word, and that single write launches one request on a narrow sideband channel. The request is a valid/ready handshake toward one port-addressed register target, and a single response pulse closes it. Read results land in the data word. Write completions leave it untouched.

Only one request is ever in flight, and the response is paired with it without tags. While the request is open a busy flag is raised and further command writes are dropped. If the target stays silent for a configurable number of cycles, the bridge abandons the request, raises an error flag and fills the data word with all ones. Read-modify-write is built in software from a read command followed by a write command to the same port and offset.

Top module: `sbm_bridge`

## Requirements
- R1: Host word index 0 is the command word, 1 the upper-offset word, 2 the data word, and 3 a read-only status word with busy at bit 0 and error at bit 1. After reset all four read zero, and the first three read back what was last accepted into them.
- R2: The command word carries the opcode in bits 31:24, the destination port in bits 23:16 and the low offset byte in bits 15:8. The offset sent on the sideband is the upper-offset word OR'd with that byte placed at bits 7:0.
- R3: Writing the upper-offset or data word never raises a sideband request. Only an accepted command write does.
- R4: Opcode bit 0 set makes the request a write (sb_req_write high). Its payload is the data word as it stood at the command write, and host data writes made later do not change it.
- R5: Opcode bit 0 clear makes the request a read. The data word keeps its previous value until the response arrives, and the response data is then stored in it.
- R6: A command write whose bits 7:0, masked with EN_MASK (default 8'hF0), differ from EN_MASK is stored but launches nothing.
- R7: Busy rises in the cycle after a launching command write and falls when the response is taken. A command write made while busy is dropped: the command word is unchanged and no second request appears.
- R8: Until sb_req_ready is seen, sb_req_valid and every request field hold steady.
- R9: If no response has been taken after TIMEOUT_CYCLES busy cycles, the request is dropped, busy falls, the error flag sets and the data word becomes all ones. The next launch clears the error flag.
- R10: A read followed by a write command to the same port and offset carries the merged value (old AND NOT mask) OR (new AND mask) that software places in the data word.
- R11: The response to a write request does not alter the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Sideband target accepts the request |
| sb_req_write | output | 1 | Request is a register write |
| sb_req_opcode | output | 8 | Request opcode |
| sb_req_port | output | 8 | Destination port |
| sb_req_offset | output | 32 | Full register offset |
| sb_req_data | output | 32 | Write payload |
| sb_rsp_valid | input | 1 | Response pulse from target |
| sb_rsp_data | input | 32 | Response read data |

## Verification
On every cycle the assertions check several behaviours. A request is never shown while idle or without a launch. The request stays steady until it is accepted. The command word is frozen while busy. A read response lands in the data word, busy never outlasts the timeout window, and an abort leaves all ones behind. The directed scenarios are what show the field packing and the offset merge. They also show the data snapshot taken at the command write, the enable-bit gating, the write-response case leaving data alone, the exact cycle of the timeout and the software read-modify-write sequence.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   localparam int unsigned REG_CMD  = 0;
   localparam int unsigned REG_EXT  = 1;
   localparam int unsigned REG_DATA = 2;
   localparam int unsigned REG_STAT = 3;

   localparam int unsigned ST_BUSY = 0;
   localparam int unsigned ST_ERR  = 1;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_WAIT = 2'd2
   } sbm_state_e;

   typedef struct packed {
      logic        wr;
      logic [7:0]  opc;
      logic [7:0]  port;
      logic [31:0] offs;
      logic [31:0] data;
   } sbm_req_t;
endpackage

// File: rtl/sbm_regs.sv
module sbm_regs (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_cmd,
   input  logic        wr_ext,
   input  logic        wr_data,
   input  logic [31:0] wdata,
   input  logic        upd_en,
   input  logic [31:0] upd_val,
   output logic [31:0] cmd_o,
   output logic [31:0] ext_o,
   output logic [31:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o  <= '0;
         ext_o  <= '0;
         data_o <= '0;
      end else begin
         if (wr_cmd) cmd_o <= wdata;
         if (wr_ext) ext_o <= wdata;
         // a completing transaction has priority over a staged host write
         if (upd_en)       data_o <= upd_val;
         else if (wr_data) data_o <= wdata;
      end
   end
endmodule

// File: rtl/sbm_tmo.sv
module sbm_tmo #(
   parameter int unsigned TIMEOUT_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic busy,
   output logic expire
);
   localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

   generate
      if (TIMEOUT_CYCLES > 0) begin : g_cnt
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (launch) cnt <= '0;
            else if (busy)   cnt <= cnt + 1'b1;
         end
         assign expire = busy && (cnt == CNT_W'(TIMEOUT_CYCLES - 1));
      end else begin : g_off
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ launch ^ busy;
         assign expire = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
   import sbm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch,
   input  sbm_req_t    new_req,
   input  logic        req_ready,
   input  logic        rsp_valid,
   input  logic [31:0] rsp_data,
   input  logic        expire,
   output logic        busy,
   output logic        err,
   output logic        req_valid,
   output sbm_req_t    req,
   output logic        upd_en,
   output logic [31:0] upd_val
);
   sbm_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         err   <= 1'b0;
         req   <= '0;
      end else begin
         case (state)
            S_IDLE: if (launch) begin
               state <= S_REQ;
               req   <= new_req;
               err   <= 1'b0;
            end
            S_REQ: begin
               if (expire) begin
                  state <= S_IDLE;
                  err   <= 1'b1;
               end else if (req_ready) begin
                  state <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (rsp_valid) begin
                  state <= S_IDLE;
               end else if (expire) begin
                  state <= S_IDLE;
                  err   <= 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      upd_en  = 1'b0;
      upd_val = rsp_data;
      case (state)
         S_REQ: if (expire) begin
            upd_en  = 1'b1;
            upd_val = '1;
         end
         S_WAIT: begin
            if (rsp_valid) begin
               upd_en = !req.wr;
            end else if (expire) begin
               upd_en  = 1'b1;
               upd_val = '1;
            end
         end
         default: ;
      endcase
   end

   assign busy      = (state != S_IDLE);
   assign req_valid = (state == S_REQ);
endmodule

// File: rtl/sbm_bridge.sv
module sbm_bridge
   import sbm_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 64,
   parameter logic [7:0]  EN_MASK        = 8'hF0,
   parameter int unsigned AW             = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [31:0]   host_wdata,
   output logic [31:0]   host_rdata,
   output logic          sb_req_valid,
   input  logic          sb_req_ready,
   output logic          sb_req_write,
   output logic [7:0]    sb_req_opcode,
   output logic [7:0]    sb_req_port,
   output logic [31:0]   sb_req_offset,
   output logic [31:0]   sb_req_data,
   input  logic          sb_rsp_valid,
   input  logic [31:0]   sb_rsp_data
);
   localparam logic [AW-1:0] A_CMD  = AW'(REG_CMD);
   localparam logic [AW-1:0] A_EXT  = AW'(REG_EXT);
   localparam logic [AW-1:0] A_DATA = AW'(REG_DATA);
   localparam logic [AW-1:0] A_STAT = AW'(REG_STAT);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("sbm_bridge: AW must be at least 2");
      end
      if (TIMEOUT_CYCLES == 1) begin : g_bad_tmo
         $error("sbm_bridge: TIMEOUT_CYCLES must be 0 (off) or at least 2");
      end
   endgenerate

   logic        busy, err_flag, launch, expire, upd_en;
   logic [31:0] upd_val, cmd_q, ext_q, data_q;
   logic        sel_cmd, sel_ext, sel_data, en_ok;
   sbm_req_t    new_req, cur_req;

   assign sel_cmd  = host_we && (host_addr == A_CMD);
   assign sel_ext  = host_we && (host_addr == A_EXT);
   assign sel_data = host_we && (host_addr == A_DATA);
   assign en_ok    = ((host_wdata[7:0] & EN_MASK) == EN_MASK);
   assign launch   = sel_cmd && !busy && en_ok;

   always_comb begin
      new_req.wr   = host_wdata[24];
      new_req.opc  = host_wdata[31:24];
      new_req.port = host_wdata[23:16];
      new_req.offs = ext_q | {24'b0, host_wdata[15:8]};
      new_req.data = data_q;
   end

   sbm_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cmd  (sel_cmd && !busy),
      .wr_ext  (sel_ext),
      .wr_data (sel_data),
      .wdata   (host_wdata),
      .upd_en  (upd_en),
      .upd_val (upd_val),
      .cmd_o   (cmd_q),
      .ext_o   (ext_q),
      .data_o  (data_q)
   );

   sbm_tmo #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .busy   (busy),
      .expire (expire)
   );

   sbm_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .new_req   (new_req),
      .req_ready (sb_req_ready),
      .rsp_valid (sb_rsp_valid),
      .rsp_data  (sb_rsp_data),
      .expire    (expire),
      .busy      (busy),
      .err       (err_flag),
      .req_valid (sb_req_valid),
      .req       (cur_req),
      .upd_en    (upd_en),
      .upd_val   (upd_val)
   );

   assign sb_req_write  = cur_req.wr;
   assign sb_req_opcode = cur_req.opc;
   assign sb_req_port   = cur_req.port;
   assign sb_req_offset = cur_req.offs;
   assign sb_req_data   = cur_req.data;

   always_comb begin
      host_rdata = '0;
      if (host_addr == A_CMD)       host_rdata = cmd_q;
      else if (host_addr == A_EXT)  host_rdata = ext_q;
      else if (host_addr == A_DATA) host_rdata = data_q;
      else if (host_addr == A_STAT) begin
         host_rdata[ST_BUSY] = busy;
         host_rdata[ST_ERR]  = err_flag;
      end
   end
endmodule

// File: rtl/sbm_bridge_chk.sv
module sbm_bridge_chk #(
   parameter int unsigned TIMEOUT_CYCLES = 64,
   parameter int unsigned AW             = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_we,
   input logic [AW-1:0] host_addr,
   input logic          sb_req_valid,
   input logic          sb_req_ready,
   input logic          sb_req_write,
   input logic [7:0]    sb_req_opcode,
   input logic [7:0]    sb_req_port,
   input logic [31:0]   sb_req_offset,
   input logic [31:0]   sb_req_data,
   input logic          sb_rsp_valid,
   input logic [31:0]   sb_rsp_data,
   input logic          busy,
   input logic          err_flag,
   input logic [31:0]   cmd_q,
   input logic [31:0]   data_q
);
   logic cmd_wr;
   assign cmd_wr = host_we && (host_addr == '0);

   int unsigned busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   p_no_spurious_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !cmd_wr |=> !sb_req_valid);

   p_valid_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req_valid |-> busy);

   p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_wr |=> $stable(cmd_q));

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req_valid && !sb_req_ready |=> (sb_req_valid || err_flag));

   p_req_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req_valid && !sb_req_ready |=> $stable(sb_req_offset) && $stable(sb_req_data)
         && $stable(sb_req_port) && $stable(sb_req_opcode) && $stable(sb_req_write));

   p_read_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !sb_req_valid && sb_rsp_valid && !sb_req_write |=> data_q == $past(sb_rsp_data));

   p_abort_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && err_flag |-> data_q == 32'hFFFF_FFFF);

   p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !err_flag);

   generate
      if (TIMEOUT_CYCLES > 0) begin : g_bound
         p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
            busy |-> busy_run < TIMEOUT_CYCLES);
      end
   endgenerate
endmodule

bind sbm_bridge sbm_bridge_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .AW(AW)) u_chk (.*);

// File: tb/sbm_bridge_tb_top.sv
module sbm_bridge_tb_top;
   localparam int unsigned TMO = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        sb_req_valid, sb_req_write;
   logic        sb_req_ready = 1'b0;
   logic [7:0]  sb_req_opcode, sb_req_port;
   logic [31:0] sb_req_offset, sb_req_data;
   logic        sb_rsp_valid = 1'b0;
   logic [31:0] sb_rsp_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   sbm_bridge #(.TIMEOUT_CYCLES(TMO), .EN_MASK(8'hF0), .AW(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
      .sb_req_write(sb_req_write), .sb_req_opcode(sb_req_opcode),
      .sb_req_port(sb_req_port), .sb_req_offset(sb_req_offset),
      .sb_req_data(sb_req_data), .sb_rsp_valid(sb_rsp_valid),
      .sb_rsp_data(sb_rsp_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(input logic [1:0] a, output logic [31:0] v);
      host_addr = a;
      #1 v = host_rdata;
   endtask

   // precondition: sb_req_valid is high at the current negedge
   task automatic finish_txn(input logic [31:0] rd);
      sb_req_ready = 1'b1;
      @(negedge clk);
      sb_req_ready = 1'b0;
      sb_rsp_valid = 1'b1; sb_rsp_data = rd;
      @(negedge clk);
      sb_rsp_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) begin
         host_rd(i[1:0], v);
         chk("R1 reset value", v, 32'h0);
      end
      chk("R1 no request at reset", {31'b0, sb_req_valid}, 32'h0);
   endtask

   task automatic t_staging();
      logic [31:0] v;
      host_wr(2'd1, 32'h0000_1200);
      chk("R3 ext write no request", {31'b0, sb_req_valid}, 32'h0);
      host_wr(2'd2, 32'h0000_A5A5);
      chk("R3 data write no request", {31'b0, sb_req_valid}, 32'h0);
      host_rd(2'd1, v); chk("R1 ext readback", v, 32'h0000_1200);
      host_rd(2'd2, v); chk("R1 data readback", v, 32'h0000_A5A5);
      host_rd(2'd3, v); chk("R3 status idle", v, 32'h0);
   endtask

   task automatic t_write();
      logic [31:0] v;
      host_wr(2'd2, 32'hCAFE_0001);
      host_wr(2'd1, 32'h0001_2300);
      host_wr(2'd0, {8'h11, 8'h05, 8'h45, 8'hF0});
      chk("R4 write request valid", {31'b0, sb_req_valid}, 32'h1);
      chk("R4 write flag", {31'b0, sb_req_write}, 32'h1);
      chk("R2 opcode field", {24'b0, sb_req_opcode}, 32'h11);
      chk("R2 port field", {24'b0, sb_req_port}, 32'h05);
      chk("R2 merged offset", sb_req_offset, 32'h0001_2345);
      chk("R4 payload", sb_req_data, 32'hCAFE_0001);
      host_rd(2'd3, v); chk("R7 busy set", v, 32'h1);
      host_wr(2'd2, 32'h0000_0077);
      chk("R8 valid held", {31'b0, sb_req_valid}, 32'h1);
      chk("R4 payload snapshot kept", sb_req_data, 32'hCAFE_0001);
      finish_txn(32'h0000_DEAD);
      host_rd(2'd3, v); chk("R7 busy cleared", v, 32'h0);
      host_rd(2'd2, v); chk("R11 write response leaves data", v, 32'h0000_0077);
   endtask

   task automatic t_read();
      logic [31:0] v;
      host_wr(2'd2, 32'h0000_1111);
      host_wr(2'd1, 32'h0000_0000);
      host_wr(2'd0, {8'h10, 8'h03, 8'h20, 8'hF0});
      chk("R5 read flag", {31'b0, sb_req_write}, 32'h0);
      chk("R2 read offset", sb_req_offset, 32'h0000_0020);
      sb_req_ready = 1'b1;
      @(negedge clk);
      sb_req_ready = 1'b0;
      host_rd(2'd2, v); chk("R5 old data while waiting", v, 32'h0000_1111);
      host_rd(2'd3, v); chk("R7 busy while waiting", v, 32'h1);
      sb_rsp_valid = 1'b1; sb_rsp_data = 32'hBEEF_0042;
      @(negedge clk);
      sb_rsp_valid = 1'b0;
      host_rd(2'd2, v); chk("R5 response stored", v, 32'hBEEF_0042);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      host_wr(2'd0, {8'h10, 8'h02, 8'h08, 8'h30});
      host_rd(2'd0, v); chk("R6 gated cmd stored", v, {8'h10, 8'h02, 8'h08, 8'h30});
      repeat (2) @(negedge clk);
      chk("R6 no request", {31'b0, sb_req_valid}, 32'h0);
      host_rd(2'd3, v); chk("R6 not busy", v, 32'h0);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      host_wr(2'd0, {8'h10, 8'h04, 8'h10, 8'hF0});
      host_wr(2'd0, {8'h11, 8'h09, 8'h99, 8'hF0});
      host_rd(2'd0, v); chk("R7 cmd ignored while busy", v, {8'h10, 8'h04, 8'h10, 8'hF0});
      chk("R7 request unchanged", {24'b0, sb_req_port}, 32'h04);
      finish_txn(32'h0000_0005);
      repeat (2) @(negedge clk);
      chk("R7 no second request", {31'b0, sb_req_valid}, 32'h0);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      host_wr(2'd0, {8'h10, 8'h06, 8'h01, 8'hF0});
      repeat (TMO - 1) @(negedge clk);
      host_rd(2'd3, v); chk("R9 still busy at last cycle", v, 32'h1);
      @(negedge clk);
      host_rd(2'd3, v); chk("R9 aborted with error", v, 32'h2);
      host_rd(2'd2, v); chk("R9 data all ones", v, 32'hFFFF_FFFF);
      chk("R9 request dropped", {31'b0, sb_req_valid}, 32'h0);
      host_wr(2'd0, {8'h10, 8'h06, 8'h01, 8'hF0});
      host_rd(2'd3, v); chk("R9 error cleared on launch", v, 32'h1);
      finish_txn(32'h0000_0001);
   endtask

   task automatic t_rmw();
      logic [31:0] old_v, merged;
      logic [31:0] mask = 32'h0000_FFFF;
      logic [31:0] nd = 32'hAAAA_5678;
      host_wr(2'd1, 32'h0000_0000);
      host_wr(2'd0, {8'h10, 8'h07, 8'h10, 8'hF0});
      finish_txn(32'hF0F0_1234);
      host_rd(2'd2, old_v);
      merged = (old_v & ~mask) | (nd & mask);
      host_wr(2'd2, merged);
      host_wr(2'd0, {8'h11, 8'h07, 8'h10, 8'hF0});
      chk("R10 merged payload", sb_req_data, 32'hF0F0_5678);
      chk("R10 same offset", sb_req_offset, 32'h0000_0010);
      chk("R10 same port", {24'b0, sb_req_port}, 32'h07);
      finish_txn(32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_staging();
      t_write();
      t_read();
      t_enable();
      t_busy_ignore();
      t_timeout();
      t_rmw();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule